// File: doc/BRIEF.md
# Stuck-At Fault Emulation Engine

This block grades a test-vector set against single stuck-at faults in a small fixed combinational circuit, F = (A AND B) XOR (B AND C). It holds two copies of that circuit: a golden copy that is never disturbed and a shadow copy in which any one of its six nets can be pinned to 0 or 1. The six nets are the three inputs, the two AND-gate outputs and F.

Software, or a test controller, writes up to `NUM_VEC` three-bit vectors into a small register array, chooses how many of them to use, and pulses `start`. A sequencer then walks every one of the twelve single faults. For each fault it applies every selected vector to both copies in the same cycle. The registered outputs of the two copies are compared one clock later. Any fault whose shadow output ever differs from the golden output gets a sticky detected bit. When the last fault has seen the last vector, the engine raises `done`. It then presents the detected mask, the number of detected faults and the fixed fault total, so coverage is `detected_count / total_faults`.

Top module: `fse_engine`

## Requirements
- R1: Fault code c covers net c[3:1] stuck at value c[0]. The nets are A=0, B=1, C=2, A&B=3, B&C=4 and F=5. This gives codes 0..11, so `total_faults` reads 12, and code 15 is reserved as "no fault". Bit c of `detected_mask` belongs to fault code c.
- R2: During a run, the shadow copy sees the applied vector with only the selected net forced, and the golden copy sees the vector unchanged. Vector bit 2 drives A, bit 1 drives B and bit 0 drives C.
- R3: A fault is marked detected only if some applied vector gives a shadow output different from the golden output. For example, vector 110 detects C stuck-at-1, A stuck-at-0 and B stuck-at-0, but not A stuck-at-1.
- R4: An accepted `start` clears `detected_mask` on the next clock. From then on, bits only rise, and the mask is frozen while the engine is idle.
- R5: `vec_count` is sampled at start. Vectors 0..n-1 are used, where n = min(`vec_count`, `NUM_VEC`). If n is 0, no vectors are applied and nothing is detected.
- R6: `busy` is high from the clock after an accepted start until `done` rises, and `done` rises exactly 12*n+1 clocks after the start edge. `done` and `busy` are never high together.
- R7: `detected_count` always equals the number of set bits in `detected_mask`.
- R8: A `start` pulse while `busy` is high is ignored. It does not change the result or the run length.
- R9: After reset, `busy`, `done`, `detected_mask` and `detected_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_wr_en | input | 1 | Write strobe for the vector array |
| vec_wr_addr | input | AW (3) | Vector array entry to write |
| vec_wr_data | input | 3 | Vector {A,B,C} |
| vec_count | input | CW (4) | Number of vectors to apply, clamped to NUM_VEC |
| start | input | 1 | Begin a grading run (accepted when not busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete; results valid until next start |
| detected_mask | output | 12 | Sticky detected bit per fault code |
| detected_count | output | 4 | Number of detected faults |
| total_faults | output | 4 | Number of modelled faults (12) |

## Verification
The bench compares every run against a spec-level model of the good and faulty circuits, so a fault forced on the wrong net, or a stuck value taken as inverted, shows up as a wrong mask bit. Vector 110 on its own is the activation corner: a design that scored a fault without activating it would wrongly flag A stuck-at-1. Running a weak vector set straight after a full-coverage run exposes a mask that is not cleared. A zero count, an over-range count and a `start` pulse in mid-run exercise the clamp and the run length; an off-by-one sequencer or a restartable run would miss the expected `done` cycle.

// File: rtl/fse_pkg.sv
`timescale 1ns/1ps
package fse_pkg;

   localparam int NUM_NETS   = 6;
   localparam int NUM_FAULTS = 2 * NUM_NETS;
   localparam int CODE_W     = $clog2(NUM_FAULTS + 1);
   localparam int CNT_W      = $clog2(NUM_FAULTS + 1);
   localparam logic [CODE_W-1:0] NO_FAULT = {CODE_W{1'b1}};

   // net index occupies code[CODE_W-1:1]; stuck value is code[0]
   typedef enum logic [CODE_W-2:0] {
      NET_A  = 0,
      NET_B  = 1,
      NET_C  = 2,
      NET_AB = 3,
      NET_BC = 4,
      NET_F  = 5
   } net_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_FLUSH,
      ST_DONE
   } seq_st_e;

   // Returns the forced value when the code selects this net, else the natural one.
   function automatic logic pin_net(logic natural, logic [CODE_W-1:0] code, net_e net);
      if ((code < CODE_W'(NUM_FAULTS)) && (code[CODE_W-1:1] == net))
         return code[0];
      return natural;
   endfunction

endpackage

// File: rtl/fse_circuit.sv
`timescale 1ns/1ps
module fse_circuit
   import fse_pkg::*;
#(
   parameter bit INJECT = 1'b1
) (
   input  logic [2:0]        vec,
   input  logic [CODE_W-1:0] code,
   output logic              f
);

   generate
      if (INJECT) begin : g_shadow
         logic a, b, c, ab, bc;
         always_comb begin
            a  = pin_net(vec[2], code, NET_A);
            b  = pin_net(vec[1], code, NET_B);
            c  = pin_net(vec[0], code, NET_C);
            ab = pin_net(a & b,  code, NET_AB);
            bc = pin_net(b & c,  code, NET_BC);
            f  = pin_net(ab ^ bc, code, NET_F);
         end
      end else begin : g_golden
         logic unused_code;
         assign unused_code = ^code;
         assign f = (vec[2] & vec[1]) ^ (vec[1] & vec[0]);
      end
   endgenerate

endmodule

// File: rtl/fse_vecmem.sv
`timescale 1ns/1ps
module fse_vecmem #(
   parameter int DEPTH = 8,
   parameter int AW    = 3
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [2:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [2:0]    rd_data
);

   logic [2:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && (32'(wr_addr) < DEPTH))
         mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fse_seq.sv
`timescale 1ns/1ps
module fse_seq
   import fse_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int AW      = 3,
   parameter int CW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CW-1:0]     vec_count,
   output logic [AW-1:0]     rd_addr,
   output logic [CODE_W-1:0] code,
   output logic              apply,
   output logic              clr,
   output logic              busy,
   output logic              done
);

   seq_st_e           st_q;
   logic [CW-1:0]     n_q;
   logic [CW-1:0]     n_eff;
   logic [AW-1:0]     vec_q;
   logic [CODE_W-1:0] flt_q;
   logic              start_ok;
   logic              last_vec;
   logic              last_flt;

   assign n_eff    = (vec_count > CW'(NUM_VEC)) ? CW'(NUM_VEC) : vec_count;
   assign start_ok = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
   assign last_vec = (CW'(vec_q) == (n_q - 1'b1));
   assign last_flt = (flt_q == CODE_W'(NUM_FAULTS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         n_q   <= '0;
         vec_q <= '0;
         flt_q <= '0;
      end else begin
         case (st_q)
            ST_RUN: begin
               if (last_vec) begin
                  vec_q <= '0;
                  if (last_flt) st_q  <= ST_FLUSH;
                  else          flt_q <= flt_q + 1'b1;
               end else begin
                  vec_q <= vec_q + 1'b1;
               end
            end
            ST_FLUSH: st_q <= ST_DONE;
            default: begin
               if (start_ok) begin
                  n_q   <= n_eff;
                  vec_q <= '0;
                  flt_q <= '0;
                  st_q  <= (n_eff == '0) ? ST_FLUSH : ST_RUN;
               end
            end
         endcase
      end
   end

   assign clr     = start_ok;
   assign apply   = (st_q == ST_RUN);
   assign code    = apply ? flt_q : NO_FAULT;
   assign rd_addr = vec_q;
   assign busy    = (st_q == ST_RUN) || (st_q == ST_FLUSH);
   assign done    = (st_q == ST_DONE);

endmodule

// File: rtl/fse_score.sv
`timescale 1ns/1ps
module fse_score
   import fse_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  valid,
   input  logic [CODE_W-1:0]     code,
   input  logic                  good,
   input  logic                  bad,
   output logic [NUM_FAULTS-1:0] mask,
   output logic [CNT_W-1:0]      count
);

   logic              valid_q;
   logic [CODE_W-1:0] code_q;
   logic              good_q;
   logic              bad_q;

   // both copies registered on the same edge before comparison
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         code_q  <= NO_FAULT;
         good_q  <= 1'b0;
         bad_q   <= 1'b0;
      end else begin
         valid_q <= valid;
         code_q  <= code;
         good_q  <= good;
         bad_q   <= bad;
      end
   end

   generate
      for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask[i] <= 1'b0;
            else if (clr)
               mask[i] <= 1'b0;
            else if (valid_q && (good_q != bad_q) && (code_q == CODE_W'(i)))
               mask[i] <= 1'b1;
         end
      end
   endgenerate

   always_comb begin
      count = '0;
      for (int i = 0; i < NUM_FAULTS; i++)
         count = count + CNT_W'(mask[i]);
   end

endmodule

// File: rtl/fse_engine.sv
`timescale 1ns/1ps
module fse_engine
   import fse_pkg::*;
#(
   parameter  int NUM_VEC = 8,
   localparam int AW      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
   localparam int CW      = $clog2(NUM_VEC + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  vec_wr_en,
   input  logic [AW-1:0]         vec_wr_addr,
   input  logic [2:0]            vec_wr_data,
   input  logic [CW-1:0]         vec_count,
   input  logic                  start,
   output logic                  busy,
   output logic                  done,
   output logic [NUM_FAULTS-1:0] detected_mask,
   output logic [CNT_W-1:0]      detected_count,
   output logic [CNT_W-1:0]      total_faults
);

   generate
      if (NUM_VEC < 1) begin : g_bad_depth
         $error("fse_engine: NUM_VEC must be at least 1");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("fse_engine: fault code too narrow");
      end
   endgenerate

   logic [AW-1:0]     rd_addr;
   logic [2:0]        cur_vec;
   logic [CODE_W-1:0] code;
   logic              apply;
   logic              clr;
   logic              f_good;
   logic              f_bad;

   fse_vecmem #(.DEPTH(NUM_VEC), .AW(AW)) u_mem (
      .clk     (clk),
      .wr_en   (vec_wr_en),
      .wr_addr (vec_wr_addr),
      .wr_data (vec_wr_data),
      .rd_addr (rd_addr),
      .rd_data (cur_vec)
   );

   fse_seq #(.NUM_VEC(NUM_VEC), .AW(AW), .CW(CW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .vec_count (vec_count),
      .rd_addr   (rd_addr),
      .code      (code),
      .apply     (apply),
      .clr       (clr),
      .busy      (busy),
      .done      (done)
   );

   fse_circuit #(.INJECT(1'b0)) u_golden (
      .vec  (cur_vec),
      .code (code),
      .f    (f_good)
   );

   fse_circuit #(.INJECT(1'b1)) u_shadow (
      .vec  (cur_vec),
      .code (code),
      .f    (f_bad)
   );

   fse_score u_score (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .valid (apply),
      .code  (code),
      .good  (f_good),
      .bad   (f_bad),
      .mask  (detected_mask),
      .count (detected_count)
   );

   assign total_faults = CNT_W'(NUM_FAULTS);

endmodule

// File: rtl/fse_engine_chk.sv
`timescale 1ns/1ps
module fse_engine_chk
   import fse_pkg::*;
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  busy,
   input logic                  done,
   input logic [NUM_FAULTS-1:0] detected_mask,
   input logic [CNT_W-1:0]      detected_count
);

   a_r4_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (detected_mask == '0));

   a_r4_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && !busy) |=> ((detected_mask & $past(detected_mask)) == $past(detected_mask)));

   a_r4_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(detected_mask));

   a_r7_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
      detected_count == CNT_W'($countones(detected_mask)));

   a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   a_r6_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

endmodule

bind fse_engine fse_engine_chk u_chk (.*);

// File: tb/fse_engine_tb.sv
`timescale 1ns/1ps
module fse_engine_tb;
   import fse_pkg::*;

   localparam int NV = 8;
   localparam int AW = 3;
   localparam int CW = 4;

   typedef struct {
      logic [NUM_FAULTS-1:0] mask;
      int                    cnt;
      int                    lat;
      int                    id;
   } exp_t;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  vec_wr_en = 1'b0;
   logic [AW-1:0]         vec_wr_addr = '0;
   logic [2:0]            vec_wr_data = '0;
   logic [CW-1:0]         vec_count = '0;
   logic                  start = 1'b0;
   logic                  busy;
   logic                  done;
   logic [NUM_FAULTS-1:0] detected_mask;
   logic [CNT_W-1:0]      detected_count;
   logic [CNT_W-1:0]      total_faults;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   start_cyc = 0;
   int   case_id = 0;
   logic [2:0] vbuf [NV];
   exp_t exp_q [$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fse_engine #(.NUM_VEC(NV)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .vec_wr_en      (vec_wr_en),
      .vec_wr_addr    (vec_wr_addr),
      .vec_wr_data    (vec_wr_data),
      .vec_count      (vec_count),
      .start          (start),
      .busy           (busy),
      .done           (done),
      .detected_mask  (detected_mask),
      .detected_count (detected_count),
      .total_faults   (total_faults)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // spec model: code = net*2 + stuck; code -1 means fault-free
   function automatic logic frc(logic nat, int code, int net);
      if (code >= 0 && code < 12 && (code / 2) == net) return logic'(code % 2);
      return nat;
   endfunction

   function automatic logic ref_f(logic [2:0] v, int code);
      logic a, b, c, ab, bc;
      a  = frc(v[2], code, 0);
      b  = frc(v[1], code, 1);
      c  = frc(v[0], code, 2);
      ab = frc(a & b, code, 3);
      bc = frc(b & c, code, 4);
      return frc(ab ^ bc, code, 5);
   endfunction

   task automatic run_case(input int n_req, input bit poke);
      exp_t e;
      int   n_eff;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         vec_wr_en   = 1'b1;
         vec_wr_addr = AW'(i);
         vec_wr_data = vbuf[i];
      end
      @(negedge clk);
      vec_wr_en = 1'b0;
      n_eff = (n_req > NV) ? NV : n_req;
      e.mask = '0;
      for (int c = 0; c < NUM_FAULTS; c++)
         for (int j = 0; j < n_eff; j++)
            if (ref_f(vbuf[j], c) != ref_f(vbuf[j], -1)) e.mask[c] = 1'b1;
      e.cnt = $countones(e.mask);
      e.lat = 12 * n_eff + 1;
      e.id  = case_id;
      exp_q.push_back(e);
      vec_count = CW'(n_req);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      start_cyc = cyc;
      chk(busy === 1'b1, "R6", "busy after start", busy, 1);
      chk(done === 1'b0, "R6", "done after start", done, 0);
      chk(detected_mask === '0, "R4", "mask cleared at start", detected_mask, 0);
      if (poke) begin
         repeat (4) @(negedge clk);
         start = 1'b1;  // R8: must be ignored
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      repeat (2) @(negedge clk);
      case_id++;
   endtask

   // monitor: pops expected results as each run completes
   initial begin
      forever begin
         exp_t e;
         @(posedge done);
         @(negedge clk);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected done", 1, 0);
         end else begin
            e = exp_q.pop_front();
            chk(detected_mask === e.mask, "R2/R3", $sformatf("case %0d mask", e.id),
                detected_mask, e.mask);
            chk(detected_count === CNT_W'(e.cnt), "R7", $sformatf("case %0d count", e.id),
                detected_count, e.cnt);
            chk((cyc - start_cyc) == e.lat, "R6/R8", $sformatf("case %0d latency", e.id),
                cyc - start_cyc, e.lat);
            chk(busy === 1'b0, "R6", $sformatf("case %0d busy at done", e.id), busy, 0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] lfsr;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(busy === 1'b0, "R9", "busy in reset", busy, 0);
      chk(done === 1'b0, "R9", "done in reset", done, 0);
      chk(detected_mask === '0, "R9", "mask in reset", detected_mask, 0);
      chk(detected_count === '0, "R9", "count in reset", detected_count, 0);
      chk(total_faults === 4'd12, "R1", "total faults", total_faults, 12);
      rst_n = 1'b1;
      @(negedge clk);

      // single vector 110
      for (int i = 0; i < NV; i++) vbuf[i] = 3'b000;
      vbuf[0] = 3'b110;
      run_case(1, 1'b0);
      chk(detected_mask[5] === 1'b1, "R3", "C stuck-1 by 110", detected_mask[5], 1);
      chk(detected_mask[0] === 1'b1, "R3", "A stuck-0 by 110", detected_mask[0], 1);
      chk(detected_mask[2] === 1'b1, "R3", "B stuck-0 by 110", detected_mask[2], 1);
      chk(detected_mask[1] === 1'b0, "R3", "A stuck-1 not activated", detected_mask[1], 0);
      chk(detected_count === 4'd6, "R7", "count for 110", detected_count, 6);

      // exhaustive vectors: full coverage
      for (int i = 0; i < NV; i++) vbuf[i] = 3'(i);
      run_case(8, 1'b0);
      chk(detected_count === total_faults, "R3", "full coverage", detected_count, 12);

      // weak set right after full coverage: mask must restart (R4)
      vbuf[0] = 3'b000;
      run_case(1, 1'b0);
      chk(detected_count === 4'd3, "R4", "count after rerun", detected_count, 3);

      // zero vectors (R5)
      run_case(0, 1'b0);
      chk(detected_mask === '0, "R5", "nothing detected with zero vectors", detected_mask, 0);

      // over-range count clamps, with ignored mid-run start (R5, R8)
      for (int i = 0; i < NV; i++) vbuf[i] = 3'(7 - i);
      run_case(15, 1'b1);

      // pseudo-random sets
      lfsr = 8'hA5;
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < NV; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            vbuf[i] = lfsr[2:0];
         end
         run_case(2 + k, k == 1);
      end

      chk(exp_q.size() == 0, "R6", "all runs completed", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule